// File: doc/BRIEF.md
# Sixteen-State Rate-Half Hard-Decision Viterbi Decoder

This block recovers one fixed-length frame of data bits from a stream of 2-bit hard-decision code symbols. The symbols come from a rate one-half convolutional encoder with four delay elements, so the trellis has sixteen states. For every symbol the block updates all sixteen path metrics in parallel and stores one survivor decision bit per state. Once the last symbol of the frame is in, it picks the state with the lowest metric and walks the stored decisions backwards. The recovered bits are presented as one parallel word. The frame is built so that its final data bits are zeros, which drives the encoder back to state zero.

Next to the data word, the block exports the total Hamming distance of the winning path. A downstream arbiter that receives the same frame over two independent channels can compare this figure and keep the channel with the smaller distance. Symbols enter through a valid/ready handshake: the block accepts one symbol, spends three cycles on it, then asks for the next one.

The controller is a single state machine with seven named states:
- LOAD: waits for a symbol and moves to ADD once one is accepted.
- ADD: forms the 32 candidate metrics, then moves to SEL.
- SEL: keeps one survivor per state and writes the decision row, then moves to NORM.
- NORM: subtracts the smallest metric from all sixteen. It returns to LOAD, or moves to BEST after the final step of the frame.
- BEST: picks the lowest-metric state and moves to TRACE.
- TRACE: reads back one decision row per cycle. After row zero it moves to DONE.
- DONE: pulses the completion flag, re-initialises the metrics and returns to LOAD.

Top module: `viterbi_r12_dec`

## Requirements
- R1: With no channel errors, `decoded[i]` equals the input bit of trellis step i for every i, where step 0 is the first symbol accepted. Each symbol is formed from the current input u and the four previous inputs (the newest is one step back). `in_sym[1]` is u xor the inputs three and four steps back (generator 23 octal). `in_sym[0]` is u xor the inputs one, two and four steps back (generator 35 octal). The encoder starts each frame in the all-zero state.
- R2: A frame containing at most three flipped symbol bits, with the flips at least 30 steps apart and at least 30 steps from the frame end, is still decoded to the original bits.
- R3: `path_metric` equals the Hamming distance between the received symbols and the code sequence of the winning path. For a correctable frame this is the number of flipped bits, and it is 0 for a clean frame. It never exceeds 2 x FRAME_LEN.
- R4: `in_ready` is high only in LOAD. A symbol is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low for exactly three cycles before it rises again, unless the frame ended.
- R5: Values on `in_sym` and `in_valid` while `in_ready` is low have no effect on the decoded bits or the path metric.
- R6: `done` is high for exactly one cycle, FRAME_LEN + 4 clock edges after the edge that accepts the final symbol. `decoded` and `path_metric` change only in a cycle where `done` is high, and hold their values until the next such cycle.
- R7: After each step the sixteen state metrics are shifted so that the smallest is zero, and every metric stays below half its register range. The exported path metric still counts the full accumulated distance.
- R8: Each frame starts from state zero with fresh metrics, so the result of a frame does not depend on any earlier frame.
- R9: While `rst_n` is low and right after reset: `in_ready` = 1, `done` = 0, `decoded` = 0, `path_metric` = 0. A reset in the middle of a frame discards that partial frame, and the next full frame decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code symbol is offered |
| in_sym | input | 2 | Hard-decision code symbol; bit 1 from generator 23, bit 0 from generator 35 (octal) |
| in_ready | output | 1 | Block can accept a symbol this cycle |
| done | output | 1 | One-cycle pulse: frame decoded |
| decoded | output | FRAME_LEN | Decoded bits; bit i belongs to trellis step i |
| path_metric | output | TOT_W | Total Hamming distance of the winning path |

## Verification
The trellis is exercised with frames of all zeros, all ones, alternating bits and two pseudo-random sequences. All-zero data keeps every branch on the zero-to-zero transition. All-ones data drives the encoder through its self-loop at state fifteen. The alternating and pseudo-random data cover cross transitions that a wrong predecessor index or generator tap would corrupt. Error-injected frames place flips in one bit of a symbol, in both bits of a symbol, and across three distant symbols. These separate survivor selection, where the decoded word must stay intact, from metric accumulation across normalisation, where the exported distance must equal the flip count. A clean frame directly after an error frame shows that metrics are reset between frames. A run that drives garbage symbols during every busy cycle shows that only handshaken symbols reach the trellis.

// File: rtl/vit_pkg.sv
package vit_pkg;

    // Trellis geometry: four delay elements give sixteen states.
    localparam int NUM_ST = 16;
    localparam int ST_W   = 4;

    // Generator taps, bit 4 = current input, bit 3 = one step back ... bit 0 = four back.
    localparam logic [4:0] GEN_HI = 5'b10011;  // 23 octal -> in_sym[1]
    localparam logic [4:0] GEN_LO = 5'b11101;  // 35 octal -> in_sym[0]

    typedef enum logic [2:0] {
        S_LOAD,
        S_ADD,
        S_SEL,
        S_NORM,
        S_BEST,
        S_TRACE,
        S_DONE
    } dec_state_e;

    // Code symbol produced when input u leaves state st (st[3] is the newest bit).
    function automatic logic [1:0] branch_sym(input logic [ST_W-1:0] st, input logic u);
        logic [4:0] win;
        win = {u, st};
        return {^(win & GEN_HI), ^(win & GEN_LO)};
    endfunction

    // Hamming distance between two 2-bit symbols.
    function automatic logic [1:0] sym_dist(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] x;
        x = a ^ b;
        return {x[1] & x[0], x[1] ^ x[0]};
    endfunction

endpackage

// File: rtl/vit_acs_array.sv
module vit_acs_array
    import vit_pkg::*;
#(
    parameter int MET_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          add_en,
    input  logic [NUM_ST-1:0][MET_W-1:0]  pm_in,
    input  logic [1:0]                    sym,
    output logic [NUM_ST-1:0][MET_W-1:0]  pm_out,
    output logic [NUM_ST-1:0]             dec_out
);

    // One add-compare-select unit per destination state. The destination
    // ns = {u, prev[3:1]} has predecessors {ns[2:0],0} and {ns[2:0],1}.
    genvar g;
    generate
        for (g = 0; g < NUM_ST; g++) begin : g_unit
            localparam int   PRED_A = (2 * g) % NUM_ST;
            localparam int   PRED_B = PRED_A + 1;
            localparam logic U_BIT  = 1'((g >> (ST_W - 1)) & 1);

            logic [1:0]       exp_a, exp_b;
            logic [MET_W-1:0] cand_a_q, cand_b_q;

            assign exp_a = branch_sym(ST_W'(PRED_A), U_BIT);
            assign exp_b = branch_sym(ST_W'(PRED_B), U_BIT);

            // Cycle 1 of a step: both candidate sums are registered.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cand_a_q <= '0;
                    cand_b_q <= '0;
                end else if (add_en) begin
                    cand_a_q <= pm_in[PRED_A] + MET_W'(sym_dist(sym, exp_a));
                    cand_b_q <= pm_in[PRED_B] + MET_W'(sym_dist(sym, exp_b));
                end
            end

            // Cycle 2: compare and select; ties keep the even predecessor.
            assign dec_out[g] = (cand_b_q < cand_a_q);
            assign pm_out[g]  = dec_out[g] ? cand_b_q : cand_a_q;
        end
    endgenerate

endmodule

// File: rtl/vit_min_pick.sv
module vit_min_pick #(
    parameter int N  = 16,
    parameter int W  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] vals,
    output logic [W-1:0]        min_val,
    output logic [IW-1:0]       min_idx
);

    // Linear scan; strict less-than keeps the lowest index on a tie.
    always_comb begin
        min_val = vals[0];
        min_idx = '0;
        for (int i = 1; i < N; i++) begin
            if (vals[i] < min_val) begin
                min_val = vals[i];
                min_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vit_surv_ram.sv
module vit_surv_ram #(
    parameter int DEPTH = 208,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] rows [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            rows[waddr] <= wdata;
        end
    end

    assign rdata = rows[raddr];

endmodule

// File: rtl/viterbi_r12_dec.sv
module viterbi_r12_dec
    import vit_pkg::*;
#(
    parameter int FRAME_LEN = 208,
    parameter int MET_W     = 8,
    parameter int TOT_W     = $clog2(2 * FRAME_LEN + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           in_sym,
    output logic                 in_ready,
    output logic                 done,
    output logic [FRAME_LEN-1:0] decoded,
    output logic [TOT_W-1:0]     path_metric
);

    localparam int                 STEP_W    = $clog2(FRAME_LEN);
    localparam logic [MET_W-1:0]   INIT_FAR  = MET_W'(1) << (MET_W - 2);
    localparam logic [STEP_W-1:0]  LAST_STEP = STEP_W'(FRAME_LEN - 1);

    dec_state_e state_q, state_d;

    logic [NUM_ST-1:0][MET_W-1:0] pm_q, pm_new;
    logic [NUM_ST-1:0]            dec_row, rd_row;
    logic [1:0]                   sym_q;
    logic [STEP_W-1:0]            step_q, tb_idx_q;
    logic [TOT_W-1:0]             offset_q, best_tot_q, metric_q;
    logic [ST_W-1:0]              tr_state_q;
    logic [FRAME_LEN-1:0]         work_q, decoded_q;
    logic [MET_W-1:0]             min_val;
    logic [ST_W-1:0]              min_idx;

    logic accept, add_en, sel_en, norm_en, best_en, trace_en, reinit;

    function automatic logic [NUM_ST-1:0][MET_W-1:0] start_metrics();
        logic [NUM_ST-1:0][MET_W-1:0] m;
        for (int i = 0; i < NUM_ST; i++) begin
            m[i] = (i == 0) ? '0 : INIT_FAR;
        end
        return m;
    endfunction

    vit_acs_array #(
        .MET_W (MET_W)
    ) u_acs (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (add_en),
        .pm_in   (pm_q),
        .sym     (sym_q),
        .pm_out  (pm_new),
        .dec_out (dec_row)
    );

    vit_min_pick #(
        .N  (NUM_ST),
        .W  (MET_W),
        .IW (ST_W)
    ) u_min (
        .vals    (pm_q),
        .min_val (min_val),
        .min_idx (min_idx)
    );

    vit_surv_ram #(
        .DEPTH (FRAME_LEN),
        .WIDTH (NUM_ST),
        .AW    (STEP_W)
    ) u_surv (
        .clk   (clk),
        .we    (sel_en),
        .waddr (step_q),
        .wdata (dec_row),
        .raddr (tb_idx_q),
        .rdata (rd_row)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_LOAD:  if (in_valid) state_d = S_ADD;
            S_ADD:   state_d = S_SEL;
            S_SEL:   state_d = S_NORM;
            S_NORM:  state_d = (step_q == LAST_STEP) ? S_BEST : S_LOAD;
            S_BEST:  state_d = S_TRACE;
            S_TRACE: if (tb_idx_q == '0) state_d = S_DONE;
            S_DONE:  state_d = S_LOAD;
        endcase
    end

    // Per-state outputs and datapath enables.
    always_comb begin
        in_ready = 1'b0;
        add_en   = 1'b0;
        sel_en   = 1'b0;
        norm_en  = 1'b0;
        best_en  = 1'b0;
        trace_en = 1'b0;
        reinit   = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            S_LOAD:  in_ready = 1'b1;
            S_ADD:   add_en   = 1'b1;
            S_SEL:   sel_en   = 1'b1;
            S_NORM:  norm_en  = 1'b1;
            S_BEST:  best_en  = 1'b1;
            S_TRACE: trace_en = 1'b1;
            S_DONE: begin
                done   = 1'b1;
                reinit = 1'b1;
            end
        endcase
    end

    assign accept = in_ready & in_valid;

    // Metrics, step counter and traceback.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q       <= start_metrics();
            sym_q      <= '0;
            step_q     <= '0;
            offset_q   <= '0;
            best_tot_q <= '0;
            tr_state_q <= '0;
            tb_idx_q   <= '0;
            work_q     <= '0;
            decoded_q  <= '0;
            metric_q   <= '0;
        end else begin
            if (accept) begin
                sym_q <= in_sym;
            end

            if (sel_en) begin
                pm_q <= pm_new;
            end else if (norm_en) begin
                for (int i = 0; i < NUM_ST; i++) begin
                    pm_q[i] <= pm_q[i] - min_val;
                end
                offset_q <= offset_q + TOT_W'(min_val);
                step_q   <= step_q + 1'b1;
            end else if (reinit) begin
                pm_q     <= start_metrics();
                offset_q <= '0;
                step_q   <= '0;
            end

            if (best_en) begin
                tr_state_q <= min_idx;
                best_tot_q <= offset_q + TOT_W'(pm_q[min_idx]);
                tb_idx_q   <= LAST_STEP;
            end

            if (trace_en) begin
                work_q[tb_idx_q] <= tr_state_q[ST_W-1];
                tr_state_q       <= {tr_state_q[ST_W-2:0], rd_row[tr_state_q]};
                if (tb_idx_q != '0) begin
                    tb_idx_q <= tb_idx_q - 1'b1;
                end else begin
                    decoded_q <= {work_q[FRAME_LEN-1:1], tr_state_q[ST_W-1]};
                    metric_q  <= best_tot_q;
                end
            end
        end
    end

    assign decoded     = decoded_q;
    assign path_metric = metric_q;

endmodule

// File: rtl/vit_chk.sv
module vit_chk
    import vit_pkg::*;
#(
    parameter int FRAME_LEN = 208,
    parameter int MET_W     = 8,
    parameter int TOT_W     = 10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic                         in_ready,
    input logic                         done,
    input logic [FRAME_LEN-1:0]         decoded,
    input logic [TOT_W-1:0]             path_metric,
    input logic [NUM_ST-1:0][MET_W-1:0] pm,
    input dec_state_e                   state
);

    logic took;
    logic pm_has_zero;
    logic pm_low;

    assign took = in_valid & in_ready;

    always_comb begin
        pm_has_zero = 1'b0;
        pm_low      = 1'b1;
        for (int i = 0; i < NUM_ST; i++) begin
            if (pm[i] == '0) pm_has_zero = 1'b1;
            if (pm[i][MET_W-1]) pm_low = 1'b0;
        end
    end

    // R4: three busy cycles follow every accepted symbol.
    p_busy_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(took, 1) || $past(took, 2) || $past(took, 3)) |-> !in_ready);

    // R6: completion flag lasts one cycle.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: results move only together with the completion flag.
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(decoded) && $stable(path_metric)));

    // R7: after normalisation some state metric is zero.
    p_norm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && $past(state) == S_NORM) |-> pm_has_zero);

    // R7: metrics keep headroom.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pm_low);

    // R3: exported distance is bounded by the symbol bit count.
    p_metric_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(path_metric) <= 2 * FRAME_LEN));

endmodule

bind viterbi_r12_dec vit_chk #(
    .FRAME_LEN (FRAME_LEN),
    .MET_W     (MET_W),
    .TOT_W     (TOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .done        (done),
    .decoded     (decoded),
    .path_metric (path_metric),
    .pm          (pm_q),
    .state       (state_q)
);

// File: tb/sim_viterbi_r12_dec.sv
module sim_viterbi_r12_dec;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_LEN  = 208;
    localparam int DATA_LEN   = 200;
    localparam int TOT_W      = 10;
    localparam int NUM_VEC    = 6;
    localparam int MAX_CYC    = 200000;

    typedef struct packed {
        logic [1:0]  mode;     // 0 zeros, 1 ones, 2 alternating, 3 LFSR
        logic [15:0] seed;
        logic [7:0]  pos0;
        logic [1:0]  flip0;
        logic [7:0]  pos1;
        logic [1:0]  flip1;
        logic [7:0]  pos2;
        logic [1:0]  flip2;
        logic [3:0]  exp_met;
    } vec_t;

    localparam vec_t VECS [NUM_VEC] = '{
        '{2'd0, 16'h0000, 8'd0,  2'b00, 8'd0,   2'b00, 8'd0,   2'b00, 4'd0},
        '{2'd1, 16'h0000, 8'd0,  2'b00, 8'd0,   2'b00, 8'd0,   2'b00, 4'd0},
        '{2'd2, 16'h0000, 8'd50, 2'b01, 8'd0,   2'b00, 8'd0,   2'b00, 4'd1},
        '{2'd3, 16'hACE1, 8'd20, 2'b11, 8'd120, 2'b10, 8'd0,   2'b00, 4'd3},
        '{2'd3, 16'h5A17, 8'd10, 2'b01, 8'd80,  2'b10, 8'd170, 2'b01, 4'd3},
        '{2'd3, 16'h1D2B, 8'd0,  2'b00, 8'd0,   2'b00, 8'd0,   2'b00, 4'd0}
    };

    logic                 clk;
    logic                 rst_n;
    logic                 in_valid;
    logic [1:0]           in_sym;
    logic                 in_ready;
    logic                 done;
    logic [FRAME_LEN-1:0] decoded;
    logic [TOT_W-1:0]     path_metric;

    logic [1:0]           tx_sym [FRAME_LEN];
    int                   n_chk;
    int                   n_fail;

    viterbi_r12_dec #(
        .FRAME_LEN (FRAME_LEN)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sym      (in_sym),
        .in_ready    (in_ready),
        .done        (done),
        .decoded     (decoded),
        .path_metric (path_metric)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [FRAME_LEN-1:0] act, input logic [FRAME_LEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FRAME_LEN-1:0] gen_data(input logic [1:0] mode, input logic [15:0] seed);
        logic [FRAME_LEN-1:0] d;
        logic [15:0]          lf;
        d  = '0;
        lf = seed;
        for (int i = 0; i < DATA_LEN; i++) begin
            case (mode)
                2'd0: d[i] = 1'b0;
                2'd1: d[i] = 1'b1;
                2'd2: d[i] = (i % 2 == 0);
                default: begin
                    d[i] = lf[0];
                    lf   = (lf >> 1) ^ (lf[0] ? 16'hB400 : 16'h0000);
                end
            endcase
        end
        return d;
    endfunction

    // Reference encoder written from R1: st[3] newest, st[0] four steps back.
    task automatic build_syms(input logic [FRAME_LEN-1:0] data);
        logic [3:0] st;
        logic       u;
        st = 4'd0;
        for (int i = 0; i < FRAME_LEN; i++) begin
            u         = data[i];
            tx_sym[i] = {u ^ st[1] ^ st[0], u ^ st[3] ^ st[2] ^ st[0]};
            st        = {u, st[3:1]};
        end
    endtask

    task automatic flip(input logic [7:0] pos, input logic [1:0] msk);
        if (msk != 2'b00) tx_sym[pos] = tx_sym[pos] ^ msk;
    endtask

    task automatic send_frame(input int nsym, input bit noise, input bit chk_busy,
                              input bit want_lat, output int lat);
        lat = 0;
        for (int i = 0; i < nsym; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_sym   = tx_sym[i];
            @(posedge clk);
            #1;
            if (noise && i != nsym - 1) begin
                in_valid = 1'b1;
                in_sym   = ~tx_sym[i];
            end else begin
                in_valid = 1'b0;
            end
            if (chk_busy && i == 0) begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check(!in_ready, "R4", "ready low while busy", FRAME_LEN'(in_ready), '0);
                end
                @(negedge clk);
                check(in_ready, "R4", "ready back after three cycles", FRAME_LEN'(in_ready), 1);
            end
        end
        if (want_lat) begin
            while (lat < 5000) begin
                @(negedge clk);
                if (done) break;
                lat++;
            end
        end
    endtask

    initial begin
        logic [FRAME_LEN-1:0] data;
        int                   lat;
        n_chk    = 0;
        n_fail   = 0;
        in_valid = 1'b0;
        in_sym   = 2'b00;
        rst_n    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "ready in reset", FRAME_LEN'(in_ready), 1);
        check(done == 1'b0, "R9", "done in reset", FRAME_LEN'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(path_metric == '0, "R9", "metric after reset", FRAME_LEN'(path_metric), 0);
        check(decoded == '0, "R9", "decoded after reset", decoded, '0);

        // Table-driven frames: R1 clean, R2 with flips, R3/R7 metric, R6 latency, R8 independence.
        for (int v = 0; v < NUM_VEC; v++) begin
            data = gen_data(VECS[v].mode, VECS[v].seed);
            build_syms(data);
            flip(VECS[v].pos0, VECS[v].flip0);
            flip(VECS[v].pos1, VECS[v].flip1);
            flip(VECS[v].pos2, VECS[v].flip2);
            send_frame(FRAME_LEN, 1'b0, v == 0, 1'b1, lat);
            if (VECS[v].exp_met == 0)
                check(decoded == data, "R1", "clean frame bits", decoded, data);
            else
                check(decoded == data, "R2", "corrected frame bits", decoded, data);
            check(path_metric == TOT_W'(VECS[v].exp_met), "R3 R7 R8", "winning path distance",
                  FRAME_LEN'(path_metric), FRAME_LEN'(VECS[v].exp_met));
            check(lat == FRAME_LEN + 4, "R6", "done latency", FRAME_LEN'(lat), FRAME_LEN'(FRAME_LEN + 4));
            if (v == 0) begin
                @(negedge clk);
                check(!done, "R6", "done one cycle", FRAME_LEN'(done), 0);
            end
            if (v == 1) begin
                repeat (5) @(negedge clk);
                check(decoded == data, "R6", "result held", decoded, data);
            end
        end

        // R5: garbage offered during every busy cycle.
        data = gen_data(VECS[3].mode, VECS[3].seed);
        build_syms(data);
        flip(VECS[3].pos0, VECS[3].flip0);
        flip(VECS[3].pos1, VECS[3].flip1);
        send_frame(FRAME_LEN, 1'b1, 1'b0, 1'b1, lat);
        check(decoded == data, "R5", "bits with busy-cycle noise", decoded, data);
        check(path_metric == TOT_W'(3), "R5", "metric with busy-cycle noise", FRAME_LEN'(path_metric), 3);

        // R9: reset in the middle of a frame.
        data = gen_data(2'd3, 16'h7777);
        build_syms(data);
        send_frame(60, 1'b0, 1'b0, 1'b0, lat);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(decoded == '0, "R9", "outputs cleared by reset", decoded, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "ready after mid-frame reset", FRAME_LEN'(in_ready), 1);
        data = gen_data(2'd2, 16'h0000);
        build_syms(data);
        send_frame(FRAME_LEN, 1'b0, 1'b0, 1'b1, lat);
        check(decoded == data, "R9", "frame after mid-frame reset", decoded, data);
        check(path_metric == '0, "R9", "metric after mid-frame reset", FRAME_LEN'(path_metric), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", MAX_CYC);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule